// File: doc/BRIEF.md
# Read-Only I2C Slave Transmitter

This block is an I2C target that answers only read requests sent to one fixed 7-bit address. It shifts bytes out of a data source port: it gives the byte position within the current transfer on `rd_index`, and the surrounding logic returns the byte for that position on `rd_data`. SCL and SDA come in as raw levels. They are synchronised and oversampled by the system clock. The only drive the block puts on the bus is an open-drain enable that pulls SDA low.

START and STOP detection sits above every state of the protocol engine. A STOP sends the engine back to idle from anywhere, including the middle of a byte. A START sends it back to address reception. Some masters acknowledge the last byte they read, which is not compliant. Even then the engine cannot be left holding SDA or waiting for a byte that will never be clocked. After an acknowledge, the slave keeps SDA released for as long as SCL stays high, so the master is always able to form the STOP. A two-bit status output reports how the most recent read ended.

Protocol states and transitions:
- IDLE: waits for START.
- ADDR: shifts in eight bits on SCL rising edges. At the next SCL fall it goes to AACK on a match with the read bit set, and to SKIP otherwise.
- AACK: drives the address acknowledge. At the SCL fall it loads the byte and goes to SEND.
- SEND: drives the bits MSB first, changing them only after SCL falls. After the eighth bit's fall it goes to MACK.
- MACK: SDA is released. On the SCL rise it samples the master. A 0 (ACK) advances the index and goes to ACKD. A 1 (NACK) goes to SKIP.
- ACKD: SDA stays released while SCL is high. At the SCL fall it loads the next byte and goes to SEND.
- SKIP: ignores the bus.
- From every state: STOP goes to IDLE, and START goes to ADDR.

Top module: `i2c_read_slave`

## Requirements
- R1: After reset, sda_oe is 0, end_code is 2'b00 (no transfer ended) and rd_index is 0.
- R2: When the address byte (7 address bits MSB first, then bit 0 = 1 for read) matches the device address, the slave pulls SDA low during the 9th clock.
- R3: If the address does not match, or bit 0 is 0 (write), the slave gives no acknowledge and does not drive SDA until the next START or STOP.
- R4: Data bytes go out MSB first. The first byte of each transfer is the source byte for rd_index 0.
- R5: When the master acknowledges (SDA 0 on the 9th SCL rise), rd_index increases by one and the byte for the new index is sent next.
- R6: When the master gives a NACK (SDA 1 on the 9th SCL rise), the slave releases SDA, drives nothing more, and sets end_code to 2'b01.
- R7: A STOP (SDA rising while SCL is high) returns the engine to idle from any state, including mid-byte, and releases SDA. If the STOP comes while a read is active (between the address acknowledge and the master's NACK), end_code becomes 2'b10. A following transfer then works normally.
- R8: A START (SDA falling while SCL is high) in any state, including mid-byte, restarts address reception and returns rd_index to 0.
- R9: After a master ACK, SDA stays released for as long as SCL stays high. A STOP after an acknowledged last byte is therefore always possible.
- R10: The slave never begins pulling SDA low while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level |
| sda_i | input | 1 | Raw SDA level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rd_index | output | IDX_W | Byte position within the current read |
| rd_data | input | DATA_W | Source byte for rd_index |
| end_code | output | 2 | How the last read ended: 00 none, 01 NACK, 10 STOP |

## Verification
Three things can fall together: the master's acknowledge decision, the loading of the next byte, and a STOP. In the hazardous case the master acknowledges the last byte, keeps SCL high and then releases SDA. The acknowledge sampling and the STOP detection then land a few system cycles apart, and the STOP has to win before any new bit is driven. The bench provokes this with the acknowledge clock held high. It judges the outcome by three things: sda_oe staying 0 through the high phase, end_code reading STOP, and a clean transfer afterwards. A START or STOP placed in the middle of an address byte or a data byte covers the other collision, between bit shifting and condition detection.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SEND,
        ST_MACK,
        ST_ACKD,
        ST_SKIP
    } rd_state_t;

    localparam logic [1:0] END_NONE = 2'b00;
    localparam logic [1:0] END_NACK = 2'b01;
    localparam logic [1:0] END_STOP = 2'b10;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_p;
    logic sda_p;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_rd_datapath.sv
module i2c_rd_datapath #(
    parameter int                  DATA_W   = 8,
    parameter logic [DATA_W-2:0]   DEV_ADDR = 7'h3C,
    parameter int                  IDX_W    = 4,
    localparam int                 CNT_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              sr_load,
    input  logic              sr_shift_in,
    input  logic              sr_shift_out,
    input  logic              cnt_clr,
    input  logic              cnt_inc,
    input  logic              idx_clr,
    input  logic              idx_inc,
    input  logic [DATA_W-1:0] load_val,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sreg_msb,
    output logic              addr_hit,
    output logic [IDX_W-1:0]  rd_index
);
    logic [DATA_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '1;
        end else if (sr_load) begin
            sreg <= load_val;
        end else if (sr_shift_in) begin
            sreg <= {sreg[DATA_W-2:0], sda_s};
        end else if (sr_shift_out) begin
            sreg <= {sreg[DATA_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (cnt_clr) begin
            bit_cnt <= '0;
        end else if (cnt_inc) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_index <= '0;
        end else if (idx_clr) begin
            rd_index <= '0;
        end else if (idx_inc) begin
            rd_index <= rd_index + 1'b1;
        end
    end

    assign sreg_msb = sreg[DATA_W-1];
    assign addr_hit = (sreg[DATA_W-1:1] == DEV_ADDR) && sreg[0];

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
    import i2c_rd_pkg::*;
#(
    parameter int  DATA_W = 8,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             sreg_msb,
    input  logic             addr_hit,
    output logic             sr_load,
    output logic             sr_shift_in,
    output logic             sr_shift_out,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             idx_clr,
    output logic             idx_inc,
    output logic             sda_oe,
    output logic [1:0]       end_code
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    rd_state_t st, nxt;
    logic      in_read;
    logic      nack_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt          = st;
        sr_load      = 1'b0;
        sr_shift_in  = 1'b0;
        sr_shift_out = 1'b0;
        cnt_clr      = 1'b0;
        cnt_inc      = 1'b0;
        idx_clr      = 1'b0;
        idx_inc      = 1'b0;
        if (stop_evt) begin
            nxt = ST_IDLE;
        end else if (start_evt) begin
            nxt     = ST_ADDR;
            cnt_clr = 1'b1;
            idx_clr = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: begin
                    if (scl_rise) begin
                        sr_shift_in = 1'b1;
                        cnt_inc     = 1'b1;
                    end else if (scl_fall && bit_cnt == FULL) begin
                        nxt = addr_hit ? ST_AACK : ST_SKIP;
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        nxt     = ST_SEND;
                        sr_load = 1'b1;
                        cnt_clr = 1'b1;
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        cnt_inc = 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == FULL) nxt = ST_MACK;
                        else                 sr_shift_out = 1'b1;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            nxt = ST_SKIP;
                        end else begin
                            nxt     = ST_ACKD;
                            idx_inc = 1'b1;
                        end
                    end
                end
                ST_ACKD: begin
                    if (scl_fall) begin
                        nxt     = ST_SEND;
                        sr_load = 1'b1;
                        cnt_clr = 1'b1;
                    end
                end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign in_read   = (st == ST_AACK) || (st == ST_SEND) ||
                       (st == ST_MACK) || (st == ST_ACKD);
    assign nack_seen = (st == ST_MACK) && scl_rise && sda_s &&
                       !start_evt && !stop_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_code <= END_NONE;
        end else if (stop_evt && in_read) begin
            end_code <= END_STOP;
        end else if (nack_seen) begin
            end_code <= END_NACK;
        end
    end

    always_comb begin
        unique case (st)
            ST_AACK: sda_oe = 1'b1;
            ST_SEND: sda_oe = ~sreg_msb;
            default: sda_oe = 1'b0;
        endcase
    end

    a_r7_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (st == ST_IDLE && !sda_oe));

    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (st == ST_ADDR && bit_cnt == '0));

    a_r10_no_drive_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(!scl_s));

    a_r6_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        nack_seen |=> (end_code == END_NACK && st == ST_SKIP && !sda_oe));

    a_r3_skip_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |=> (st == ST_SKIP || st == ST_IDLE || st == ST_ADDR));

endmodule

// File: rtl/i2c_read_slave.sv
module i2c_read_slave #(
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h3C,
    parameter int                IDX_W       = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [IDX_W-1:0]  rd_index,
    input  logic [DATA_W-1:0] rd_data,
    output logic [1:0]        end_code
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic sr_load, sr_shift_in, sr_shift_out;
    logic cnt_clr, cnt_inc, idx_clr, idx_inc;
    logic sreg_msb, addr_hit;
    logic [CNT_W-1:0] bit_cnt;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_rd_datapath #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .sr_load(sr_load), .sr_shift_in(sr_shift_in), .sr_shift_out(sr_shift_out),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .idx_clr(idx_clr), .idx_inc(idx_inc),
        .load_val(rd_data), .bit_cnt(bit_cnt), .sreg_msb(sreg_msb),
        .addr_hit(addr_hit), .rd_index(rd_index)
    );

    i2c_rd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .bit_cnt(bit_cnt), .sreg_msb(sreg_msb), .addr_hit(addr_hit),
        .sr_load(sr_load), .sr_shift_in(sr_shift_in), .sr_shift_out(sr_shift_out),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .idx_clr(idx_clr), .idx_inc(idx_inc),
        .sda_oe(sda_oe), .end_code(end_code)
    );

endmodule

// File: tb/i2c_read_slave_tb.sv
module i2c_read_slave_tb;
    localparam int Q = 12;
    localparam int H = 24;
    localparam int NV = 6;
    // {addr[15:9], rw[8], nbytes[7:4], last_nack[3], exp_ack[2], pad[1:0]}
    localparam logic [15:0] VEC [NV] = '{
        {7'h3C, 1'b1, 4'd1, 1'b1, 1'b1, 2'b00},
        {7'h3C, 1'b1, 4'd3, 1'b1, 1'b1, 2'b00},
        {7'h3C, 1'b1, 4'd2, 1'b0, 1'b1, 2'b00},
        {7'h3D, 1'b1, 4'd1, 1'b1, 1'b0, 2'b00},
        {7'h3C, 1'b0, 4'd1, 1'b1, 1'b0, 2'b00},
        {7'h3C, 1'b1, 4'd5, 1'b1, 1'b1, 2'b00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [3:0] rd_index;
    logic [7:0] rd_data;
    logic [1:0] end_code;
    wire  sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail = 0;
    int hi_drive = 0;
    bit done = 0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [3:0] i);
        return 8'hA5 ^ (8'(i) * 8'h3B);
    endfunction

    assign rd_data = pat(rd_index);

    i2c_read_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .rd_index(rd_index), .rd_data(rd_data), .end_code(end_code)
    );

    // R10 monitor: the pull-down must not start while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe && !prev_oe && scl_m && prev_scl) hi_drive++;
        prev_oe  <= sda_oe;
        prev_scl <= scl_m;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic do_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(H / 2);
        b = sda_line; tick(H / 2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack);
    endtask

    task automatic get_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
    endtask

    // ACK with SCL left high, then release SDA to form STOP
    task automatic ack_hold_stop(output int oe_seen);
        oe_seen = 0;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1;
        for (int i = 0; i < 2 * H; i++) begin
            tick(1);
            if (sda_oe) oe_seen++;
        end
        sda_m = 1'b1; tick(Q);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic [1:0] exp_end;
        int oe_seen;

        tick(5);
        // R1: reset state
        check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        check(end_code == 2'b00, "R1 end_code", end_code, 0);
        check(rd_index == 4'd0, "R1 rd_index", rd_index, 0);
        rst_n = 1'b1;
        tick(10);
        exp_end = 2'b00;

        for (int v = 0; v < NV; v++) begin
            logic [6:0] a;
            logic rw, lnack, eack;
            int nb;
            a = VEC[v][15:9]; rw = VEC[v][8]; nb = int'(VEC[v][7:4]);
            lnack = VEC[v][3]; eack = VEC[v][2];
            do_start();
            put_byte({a, rw}, ack);
            check(ack == !eack, eack ? "R2 address ack" : "R3 no ack", ack, !eack);
            if (eack) begin
                for (int k = 0; k < nb; k++) begin
                    get_byte(b);
                    check(b == pat(4'(k)), k == 0 ? "R4 first byte" : "R5 next byte", b, pat(4'(k)));
                    if (k < nb - 1) begin
                        put_bit(1'b0);
                    end else if (lnack) begin
                        put_bit(1'b1);
                        check(end_code == 2'b01 && !sda_oe, "R6 nack end", end_code, 1);
                        exp_end = 2'b01;
                    end
                end
                if (lnack) begin
                    do_stop();
                end else begin
                    ack_hold_stop(oe_seen);
                    check(oe_seen == 0, "R9 released after ack", oe_seen, 0);
                    exp_end = 2'b10;
                end
            end else begin
                get_byte(b);
                check(b == 8'hFF, "R3 ignored read", b, 8'hFF);
                put_bit(1'b1);
                do_stop();
            end
            tick(4);
            check(end_code == exp_end, "R7 end code after stop", end_code, exp_end);
        end

        // R8: START in mid address byte
        do_start();
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        do_start();
        put_byte({7'h3C, 1'b1}, ack);
        check(ack == 1'b0, "R8 ack after mid-address restart", ack, 0);
        get_byte(b);
        check(b == pat(4'd0), "R8 data after restart", b, pat(4'd0));
        put_bit(1'b0);
        // three bits of byte 1 (1,0,0), slave then drives a 1 (released)
        for (int i = 0; i < 3; i++) get_bit(ack);
        do_start();
        check(rd_index == 4'd0, "R8 index reset", rd_index, 0);
        put_byte({7'h3C, 1'b1}, ack);
        get_byte(b);
        check(b == pat(4'd0), "R8 mid-byte restart data", b, pat(4'd0));
        put_bit(1'b1);
        do_stop();

        // R7: STOP in mid data byte after two bits (1,0); slave releases for a 1
        do_start();
        put_byte({7'h3C, 1'b1}, ack);
        get_bit(ack);
        get_bit(ack);
        do_stop();
        tick(4);
        check(end_code == 2'b10, "R7 mid-byte stop code", end_code, 2);
        check(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);

        // R9 then R7 recovery: acknowledged last byte with SCL held high
        do_start();
        put_byte({7'h3C, 1'b1}, ack);
        get_byte(b);
        put_bit(1'b1);
        do_stop();
        check(end_code == 2'b01, "R6 nack before hold test", end_code, 1);
        do_start();
        put_byte({7'h3C, 1'b1}, ack);
        get_byte(b);
        ack_hold_stop(oe_seen);
        check(oe_seen == 0, "R9 no drive while scl high", oe_seen, 0);
        tick(4);
        check(end_code == 2'b10, "R7 stop after acked last byte", end_code, 2);
        do_start();
        put_byte({7'h3C, 1'b1}, ack);
        check(ack == 1'b0, "R7 recovery ack", ack, 0);
        get_byte(b);
        check(b == pat(4'd0), "R7 recovery data", b, pat(4'd0));
        put_bit(1'b1);
        do_stop();

        check(hi_drive == 0, "R10 drive start with scl high", hi_drive, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule